// File: doc/BRIEF.md
# Stuck-Low Bus Timeout Monitor

This block guards a two-wire bus hub against a downstream segment that holds a line low indefinitely. It observes the shared downstream data and clock levels, already synchronized and reduced to digital high/low values. While either line sits low, it counts prescaled time ticks. If the count reaches the limit picked by a 2-bit select, it raises a timeout and issues a one-cycle disconnect command. The connection controller uses that command to detach every downstream channel, which frees the upstream bus.

The block reports two timeout bits. The live bit follows the present state of the timer. The sticky bit holds until a fault-clear strobe arrives. While the sticky bit is set, an active-low alert output is held low. The tick input is expected to pulse once every 0.5 ms, and the tick counts per setting are parameters.

All pins are plain control and status signals. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `stuck_low_monitor`

## Requirements
- R1: After reset, `to_live`, `to_sticky` and `disc_pulse` are 0 and `alert_n` is 1.
- R2: The timer advances by one on each clock edge that samples `tick`=1 while `sda_in`=0 or `scl_in`=0 (either line alone is enough). Cycles with `tick`=0 do not advance it.
- R3: A clock edge that samples both `sda_in`=1 and `scl_in`=1 resets the timer to zero. A later low period needs the full limit again.
- R4: The limit in ticks follows `tsel`: 2'b01 gives 60 ticks (30 ms), 2'b10 gives 30 ticks (15 ms), 2'b11 gives 15 ticks (7.5 ms). `to_live` becomes 1 right after the edge that counts the limit-th tick, and stays 1 while the lines remain low.
- R5: `tsel`=2'b00 disables the feature. The timer is held at zero and `to_live` stays 0 however long a line stays low.
- R6: `disc_pulse` is high for exactly one cycle: the first cycle in which `to_live` is 1. It does not repeat while the bus stays stuck.
- R7: `to_sticky` is set on the edge after any cycle with `to_live`=1. It is held after the bus is released. `alert_n` is 0 exactly while `to_sticky` is 1.
- R8: A `fault_clr` strobe clears `to_sticky` on the next edge, unless `to_live` is still 1 in that cycle.
- R9: `to_live` returns to 0 on the edge that samples both lines high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sda_in | input | 1 | Synchronized downstream data level, 1 = high |
| scl_in | input | 1 | Synchronized downstream clock level, 1 = high |
| tick | input | 1 | Prescaled 0.5 ms time tick, one cycle wide |
| tsel | input | 2 | Timeout select: 00 off, 01 long, 10 mid, 11 short |
| fault_clr | input | 1 | Fault-clear strobe for the sticky bit |
| to_live | output | 1 | Present timeout state |
| to_sticky | output | 1 | Latched timeout state |
| disc_pulse | output | 1 | One-cycle command to disconnect all channels |
| alert_n | output | 1 | Active-low fault alert |

## Verification
A timer that counts on the wrong condition, or that fails to clear, shows up as `to_live` rising one or more ticks too early or too late against the arithmetic limit. The bench compares `to_live` every cycle, so such an error is caught on the exact cycle of the expected expiry. A fault in the edge-detect or sticky state appears as a missing, doubled or stretched `disc_pulse`, or as an `alert_n` that is wrong on the cycle after expiry or after a clear strobe. Sweeping every select code against each line pattern exposes any limit decoding error within one timeout window.

// File: rtl/stlm_pkg.sv
package stlm_pkg;
  typedef enum logic [1:0] {
    SEL_OFF   = 2'b00,
    SEL_LONG  = 2'b01,
    SEL_MID   = 2'b10,
    SEL_SHORT = 2'b11
  } tsel_e;
endpackage

// File: rtl/stlm_limit_sel.sv
module stlm_limit_sel
  import stlm_pkg::*;
#(
  parameter int TICKS_LONG  = 60,
  parameter int TICKS_MID   = 30,
  parameter int TICKS_SHORT = 15,
  parameter int CNT_W       = 6
) (
  input  logic [1:0]       tsel,
  output logic             en,
  output logic [CNT_W-1:0] limit
);
  always_comb begin
    en    = 1'b1;
    limit = CNT_W'(TICKS_LONG);
    unique case (tsel_e'(tsel))
      SEL_OFF:   begin en = 1'b0; limit = CNT_W'(TICKS_LONG); end
      SEL_LONG:  limit = CNT_W'(TICKS_LONG);
      SEL_MID:   limit = CNT_W'(TICKS_MID);
      SEL_SHORT: limit = CNT_W'(TICKS_SHORT);
      default:   begin en = 1'b0; limit = CNT_W'(TICKS_LONG); end
    endcase
  end
endmodule

// File: rtl/stlm_timer.sv
module stlm_timer #(
  parameter int SAT   = 60,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_low,
  input  logic             en,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic             expired
);
  localparam logic [CNT_W-1:0] SAT_V = CNT_W'(SAT);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt <= '0;
    else if (!bus_low || !en)  cnt <= '0;
    else if (tick && cnt < SAT_V) cnt <= cnt + 1'b1;
  end

  assign expired = en && (cnt >= limit);
endmodule

// File: rtl/stlm_status.sv
module stlm_status (
  input  logic clk,
  input  logic rst_n,
  input  logic live,
  input  logic fault_clr,
  output logic sticky,
  output logic pulse
);
  logic live_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_d <= 1'b0;
      sticky <= 1'b0;
    end else begin
      live_d <= live;
      if (live)           sticky <= 1'b1;
      else if (fault_clr) sticky <= 1'b0;
    end
  end

  assign pulse = live && !live_d;
endmodule

// File: rtl/stuck_low_monitor.sv
module stuck_low_monitor #(
  parameter int TICKS_LONG  = 60,
  parameter int TICKS_MID   = 30,
  parameter int TICKS_SHORT = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_in,
  input  logic       scl_in,
  input  logic       tick,
  input  logic [1:0] tsel,
  input  logic       fault_clr,
  output logic       to_live,
  output logic       to_sticky,
  output logic       disc_pulse,
  output logic       alert_n
);
  localparam int CNT_W = $clog2(TICKS_LONG + 1);

  logic             en;
  logic [CNT_W-1:0] limit;
  logic             bus_low;

  assign bus_low = !sda_in || !scl_in;

  stlm_limit_sel #(
    .TICKS_LONG(TICKS_LONG), .TICKS_MID(TICKS_MID),
    .TICKS_SHORT(TICKS_SHORT), .CNT_W(CNT_W)
  ) u_sel (
    .tsel(tsel), .en(en), .limit(limit)
  );

  stlm_timer #(.SAT(TICKS_LONG), .CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .bus_low(bus_low), .en(en),
    .tick(tick), .limit(limit), .expired(to_live)
  );

  stlm_status u_stat (
    .clk(clk), .rst_n(rst_n), .live(to_live), .fault_clr(fault_clr),
    .sticky(to_sticky), .pulse(disc_pulse)
  );

  assign alert_n = !to_sticky;
endmodule

// File: rtl/stuck_low_monitor_chk.sv
module stuck_low_monitor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sda_in,
  input logic       scl_in,
  input logic [1:0] tsel,
  input logic       fault_clr,
  input logic       to_live,
  input logic       to_sticky,
  input logic       disc_pulse
);
  p_pulse_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    disc_pulse |=> !disc_pulse);
  p_pulse_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
    disc_pulse |-> to_live);
  p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_in && scl_in) |=> !to_live);
  p_disabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tsel == 2'b00) |-> !to_live);
  p_sticky_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    to_live |=> to_sticky);
  p_sticky_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (to_sticky && !fault_clr) |=> to_sticky);
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_clr && !to_live) |=> !to_sticky);
endmodule

bind stuck_low_monitor stuck_low_monitor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sda_in(sda_in), .scl_in(scl_in),
  .tsel(tsel), .fault_clr(fault_clr), .to_live(to_live),
  .to_sticky(to_sticky), .disc_pulse(disc_pulse)
);

// File: tb/stuck_low_monitor_bench.sv
module stuck_low_monitor_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sda_in = 1'b1, scl_in = 1'b1, tick = 1'b0, fault_clr = 1'b0;
  logic [1:0] tsel = 2'b00;
  logic to_live, to_sticky, disc_pulse, alert_n;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  int  nt = 0;
  bit  e_live = 0, e_stk = 0, e_pulse = 0;

  always #10 clk = ~clk;

  stuck_low_monitor u_stuck_low_monitor (
    .clk(clk), .rst_n(rst_n), .sda_in(sda_in), .scl_in(scl_in), .tick(tick),
    .tsel(tsel), .fault_clr(fault_clr), .to_live(to_live), .to_sticky(to_sticky),
    .disc_pulse(disc_pulse), .alert_n(alert_n)
  );

  function automatic int lim_of(input logic [1:0] s);
    case (s)
      2'b01: return 60;
      2'b10: return 30;
      2'b11: return 15;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_all(input string tag);
    chk(tag, "to_live", to_live, e_live);
    chk("R6", "disc_pulse", disc_pulse, e_pulse);
    chk("R7", "to_sticky", to_sticky, e_stk);
    chk("R7", "alert_n", alert_n, !e_stk);
  endtask

  // At a negedge: check, drive, advance the model to the next posedge.
  task automatic step(input logic s, input logic c, input logic t,
                      input logic clr, input logic [1:0] sel, input string tag);
    bit prev;
    check_all(tag);
    sda_in = s; scl_in = c; tick = t; fault_clr = clr; tsel = sel;
    prev = e_live;
    e_stk = prev ? 1'b1 : (clr ? 1'b0 : e_stk);
    if ((s && c) || sel == 2'b00) nt = 0;
    else if (t && nt < 60) nt++;
    e_live  = (sel != 2'b00) && (nt >= lim_of(sel));
    e_pulse = e_live && !prev;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1", "to_live", to_live, 1'b0);
    chk("R1", "to_sticky", to_sticky, 1'b0);
    chk("R1", "disc_pulse", disc_pulse, 1'b0);
    chk("R1", "alert_n", alert_n, 1'b1);

    // R4 / R5 / R2: sweep every select against every line pattern
    for (int sel = 0; sel < 4; sel++) begin
      for (int pat = 1; pat < 4; pat++) begin
        for (int k = 0; k < 70; k++)
          step(!pat[0], !pat[1], 1'b1, 1'b0, 2'(sel), sel == 0 ? "R5" : "R4");
        for (int k = 0; k < 3; k++) step(1, 1, 1, 0, 2'(sel), "R9");
        step(1, 1, 0, 1, 2'(sel), "R8");
        step(1, 1, 0, 0, 2'(sel), "R8");
      end
    end

    // R2: sparse ticks, only ticking cycles count
    for (int k = 0; k < 60; k++) step(0, 1, (k % 3) == 0, 0, 2'b11, "R2");
    step(1, 1, 0, 0, 2'b11, "R9");
    step(1, 1, 0, 1, 2'b11, "R8");

    // R3: a single high cycle restarts the timer
    for (int k = 0; k < 10; k++) step(1, 0, 1, 0, 2'b11, "R3");
    step(1, 1, 1, 0, 2'b11, "R3");
    for (int k = 0; k < 14; k++) step(0, 1, 1, 0, 2'b11, "R3");
    for (int k = 0; k < 4; k++) step(0, 1, 1, 0, 2'b11, "R3");

    // R8: clear while still stuck keeps sticky set
    step(0, 1, 1, 1, 2'b11, "R8");
    step(0, 1, 1, 0, 2'b11, "R8");
    step(1, 1, 0, 0, 2'b11, "R9");
    step(1, 1, 0, 0, 2'b11, "R7");
    step(1, 1, 0, 1, 2'b11, "R8");
    step(1, 1, 0, 0, 2'b10, "R8");

    // R5: switching to off mid-timeout drops live; re-enable restarts
    for (int k = 0; k < 32; k++) step(0, 0, 1, 0, 2'b10, "R4");
    step(0, 0, 1, 0, 2'b00, "R5");
    for (int k = 0; k < 5; k++) step(0, 0, 1, 0, 2'b10, "R5");
    check_all("R5");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule